// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block paces the refresh work of an asynchronous DRAM controller. After reset it holds off all refresh requests for a programmable power-up delay. It then demands a fixed number of initialization refreshes from the command sequencer, and only after that does it signal that normal accesses may begin. From then on it produces one refresh obligation per refresh interval. The interval is derived so that all rows are covered once per retention window, which by default is 2048 rows in 32 ms, about one every 15.6 µs.

Obligations that the sequencer has not yet serviced collect in a bounded backlog. The request line stays high while any are outstanding. When the backlog is full, the request turns urgent, and the sequencer must then pre-empt host traffic. The sequencer services a request by pulsing the grant. It may carry out the refresh in whatever form it likes, including a hidden refresh that follows a read or write. For the row-addressed refresh style the block supplies the next row from its own counter. For the counter-based style, where the device keeps the row address internally, the block's row counter is left alone.

The FSM has three states. `ST_WAIT_POWER` counts the power-up delay and moves to `ST_INIT_REF` when the delay expires. `ST_INIT_REF` requests refreshes continuously and moves to `ST_ACTIVE` on the last initialization grant. `ST_ACTIVE` is the steady-state scheduling state and is left only by reset.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, and right after its release, ref_req, ref_urgent and init_done are 0, and ref_row and pend_cnt are 0.
- R2: After reset is released, ref_req stays 0 for the first POWERUP_NS/CLK_NS clock edges. From that edge onward, ref_req and ref_urgent are both 1.
- R3: During initialization, ref_req and ref_urgent stay 1 until INIT_REFRESHES grants have been taken. init_done rises after the edge that takes the last of them and then stays 1 until reset. pend_cnt is 0 at that point.
- R4: Once init_done is 1, pend_cnt rises by one every REFRESH_WINDOW_NS/ROWS_PER_WINDOW/CLK_NS clock edges, and ref_req is 1 exactly when pend_cnt is nonzero.
- R5: pend_cnt never exceeds MAX_PENDING. A due refresh that arrives while the count is at the limit is dropped. ref_urgent is 1 in the active phase exactly when pend_cnt equals MAX_PENDING.
- R6: A grant taken while ref_req is 1 lowers pend_cnt by one. If a grant and a due refresh land on the same edge, pend_cnt is unchanged.
- R7: A grant given while ref_req is 0 is ignored: pend_cnt and ref_row keep their values.
- R8: With ras_only_mode = 1, every taken grant advances ref_row by one, modulo 2^ROW_BITS (2048 by default), so 2047 is followed by 0. With ras_only_mode = 0 (counter-based refresh), taken grants leave ref_row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1: row-addressed refresh using ref_row; 0: device-counter refresh |
| ref_grant | input | 1 | Sequencer has issued the requested refresh (one-cycle pulse) |
| ref_req | output | 1 | A refresh is owed |
| ref_urgent | output | 1 | Refresh must pre-empt host traffic |
| ref_row | output | ROW_BITS (11) | Row address for the next row-addressed refresh |
| pend_cnt | output | clog2(MAX_PENDING+1) (4) | Refreshes owed and not yet serviced |
| init_done | output | 1 | Power-up delay and initialization refreshes are complete |

## Verification
The power-up delay is probed on both sides of its boundary edge, so an off-by-one in the delay counter shows up. The initialization count is checked after one grant short of the limit and again at the limit. In the active phase, three grant patterns are used:
- no grant at all, to show both the interval spacing and the saturation at the backlog limit;
- isolated grants, to show the decrement, the effect of each refresh style and that grants without a request are ignored;
- a grant placed on the exact edge of a due refresh, which separates correct simultaneous handling from a lost or doubled update.

A run of 2048 row-addressed grants drives the row counter through its wrap and back to its start value.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_POWER,
        ST_INIT_REF,
        ST_ACTIVE
    } rs_state_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the counter never passes the terminal count
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < PERIOD);
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    input  logic take,
    output logic [$clog2(MAX_PEND+1)-1:0] count
);
    localparam int PW = $clog2(MAX_PEND + 1);

    logic dec;
    logic inc;

    assign dec = take && (count != '0);
    assign inc = due && ((count != PW'(MAX_PEND)) || dec);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    p_pend_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= MAX_PEND);

    p_pend_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == int'($past(count))) ||
        (int'(count) == int'($past(count)) + 1) ||
        (int'(count) + 1 == int'($past(count))));
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [ROW_BITS-1:0] row
);
    localparam logic [ROW_BITS-1:0] ONE = {{(ROW_BITS-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (adv) begin
            row <= row + ONE;
        end
    end

    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> ($past(adv) && (row == $past(row) + ONE)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_NS            = 10,
    parameter int REFRESH_WINDOW_NS = 32_000_000,
    parameter int ROWS_PER_WINDOW   = 2048,
    parameter int POWERUP_NS        = 200_000,
    parameter int INIT_REFRESHES    = 8,
    parameter int MAX_PENDING       = 8,
    parameter int ROW_BITS          = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ras_only_mode,
    input  logic                               ref_grant,
    output logic                               ref_req,
    output logic                               ref_urgent,
    output logic [ROW_BITS-1:0]                ref_row,
    output logic [$clog2(MAX_PENDING+1)-1:0]   pend_cnt,
    output logic                               init_done
);
    localparam int REFI_CYC = REFRESH_WINDOW_NS / ROWS_PER_WINDOW / CLK_NS;
    localparam int PWR_CYC  = POWERUP_NS / CLK_NS;
    localparam int PWR_W    = (PWR_CYC > 2) ? $clog2(PWR_CYC) : 1;
    localparam int INIT_W   = $clog2(INIT_REFRESHES + 1);
    localparam int PEND_W   = $clog2(MAX_PENDING + 1);

    rs_state_t         state;
    rs_state_t         state_nx;
    logic [PWR_W-1:0]  pwr_cnt;
    logic [INIT_W-1:0] init_cnt;
    logic              pwr_last;
    logic              init_last;
    logic              grant_ok;
    logic              active;
    logic              due;

    assign pwr_last  = (pwr_cnt == PWR_W'(PWR_CYC - 1));
    assign init_last = (init_cnt == INIT_W'(INIT_REFRESHES - 1));
    assign grant_ok  = ref_req && ref_grant;
    assign active    = (state == ST_ACTIVE);

    // State register and phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_POWER;
            pwr_cnt  <= '0;
            init_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT_POWER && !pwr_last) begin
                pwr_cnt <= pwr_cnt + 1'b1;
            end
            if (state == ST_INIT_REF && grant_ok) begin
                init_cnt <= init_cnt + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_POWER: if (pwr_last) state_nx = ST_INIT_REF;
            ST_INIT_REF:   if (grant_ok && init_last) state_nx = ST_ACTIVE;
            ST_ACTIVE:     state_nx = ST_ACTIVE;
            default:       state_nx = ST_WAIT_POWER;
        endcase
    end

    // Outputs
    always_comb begin
        ref_req    = 1'b0;
        ref_urgent = 1'b0;
        init_done  = 1'b0;
        unique case (state)
            ST_WAIT_POWER: begin
                ref_req    = 1'b0;
                ref_urgent = 1'b0;
            end
            ST_INIT_REF: begin
                ref_req    = 1'b1;
                ref_urgent = 1'b1;
            end
            ST_ACTIVE: begin
                init_done  = 1'b1;
                ref_req    = (pend_cnt != '0);
                ref_urgent = (pend_cnt == PEND_W'(MAX_PENDING));
            end
            default: ;
        endcase
    end

    ref_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .tick  (due)
    );

    ref_backlog #(.MAX_PEND(MAX_PENDING)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .due   (due),
        .take  (grant_ok && active),
        .count (pend_cnt)
    );

    ref_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (grant_ok && ras_only_mode),
        .row   (ref_row)
    );

    p_done_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(ref_grant));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_urgent_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    p_no_pend_before_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (pend_cnt == '0));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_NS     = 2048 * 200;
    localparam int PWR_NS     = 500;
    localparam int REFI       = WIN_NS / 2048 / CLK_PERIOD;   // 20
    localparam int PWR        = PWR_NS / CLK_PERIOD;          // 50
    localparam int NINIT      = 8;
    localparam int MAXP       = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_only_mode = 1'b1;
    logic        ref_grant = 1'b0;
    logic        ref_req;
    logic        ref_urgent;
    logic [10:0] ref_row;
    logic [3:0]  pend_cnt;
    logic        init_done;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(
        .CLK_NS(CLK_PERIOD), .REFRESH_WINDOW_NS(WIN_NS), .ROWS_PER_WINDOW(2048),
        .POWERUP_NS(PWR_NS), .INIT_REFRESHES(NINIT), .MAX_PENDING(MAXP), .ROW_BITS(11)
    ) i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode), .ref_grant(ref_grant),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_row(ref_row),
        .pend_cnt(pend_cnt), .init_done(init_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_grant();
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
    endtask

    task automatic wait_pend(input int target, input int lim, input string tag);
        int n = 0;
        while (int'(pend_cnt) != target && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(pend_cnt), target);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req", ref_req, 0);
        chk("R1 urgent", ref_urgent, 0);
        chk("R1 init_done", init_done, 0);
        chk("R1 row", ref_row, 0);
        chk("R1 pend", pend_cnt, 0);
    endtask

    task automatic t_powerup();
        rst_n = 1'b1;
        chk("R1 after release req", ref_req, 0);
        repeat (PWR - 1) @(negedge clk);
        chk("R2 req before delay end", ref_req, 0);
        @(negedge clk);
        chk("R2 req at delay end", ref_req, 1);
        chk("R2 urgent at delay end", ref_urgent, 1);
    endtask

    task automatic t_init();
        repeat (5) @(negedge clk);
        chk("R3 req held without grants", ref_req, 1);
        for (int i = 0; i < NINIT - 1; i++) pulse_grant();
        chk("R3 not done one short", init_done, 0);
        chk("R3 urgent one short", ref_urgent, 1);
        pulse_grant();
        chk("R3 done after last grant", init_done, 1);
        chk("R3 pend zero", pend_cnt, 0);
        chk("R8 row after init grants", ref_row, NINIT);
    endtask

    task automatic t_ignored();
        chk("R4 req low with empty backlog", ref_req, 0);
        pulse_grant();
        chk("R7 pend unchanged", pend_cnt, 0);
        chk("R7 row unchanged", ref_row, NINIT);
    endtask

    task automatic t_interval();
        wait_pend(1, REFI + 5, "R4 first due");
        chk("R4 req with backlog", ref_req, 1);
        repeat (REFI - 1) @(negedge clk);
        chk("R4 no early second due", pend_cnt, 1);
        @(negedge clk);
        chk("R4 second due on interval", pend_cnt, 2);
        chk("R3 done sticky", init_done, 1);
    endtask

    task automatic t_cbr();
        int r = int'(ref_row);
        ras_only_mode = 1'b0;
        pulse_grant();
        chk("R6 grant decrements", pend_cnt, 1);
        chk("R8 device-counter grant keeps row", ref_row, r);
        ras_only_mode = 1'b1;
    endtask

    task automatic t_simul();
        int p;
        int r;
        p = int'(pend_cnt);
        wait_pend(p + 1, REFI + 5, "R4 due before overlap");
        p = int'(pend_cnt);
        r = int'(ref_row);
        repeat (REFI - 1) @(negedge clk);
        pulse_grant();
        chk("R6 grant and due together", pend_cnt, p);
        chk("R8 row step on overlap", ref_row, r + 1);
    endtask

    task automatic t_saturate();
        wait_pend(MAXP, REFI * (MAXP + 2), "R5 reach limit");
        chk("R5 urgent at limit", ref_urgent, 1);
        repeat (REFI + 3) @(negedge clk);
        chk("R5 no overflow", pend_cnt, MAXP);
        pulse_grant();
        chk("R6 drain from limit", pend_cnt, MAXP - 1);
        chk("R5 urgent clears", ref_urgent, 0);
    endtask

    task automatic t_wrap();
        int r0 = int'(ref_row);
        int prev;
        int bad = 0;
        int wraps = 0;
        for (int i = 0; i < 2048; i++) begin
            while (!ref_req) @(negedge clk);
            prev = int'(ref_row);
            pulse_grant();
            if (int'(ref_row) != ((prev + 1) % 2048)) bad++;
            if (prev == 2047 && ref_row == 0) wraps++;
        end
        chk("R8 step errors", bad, 0);
        chk("R8 wrap seen", wraps, 1);
        chk("R8 full cycle returns", ref_row, r0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_powerup();
        t_init();
        t_ignored();
        t_interval();
        t_cbr();
        t_simul();
        t_saturate();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule